// File: doc/BRIEF.md
# EDO DRAM Access Controller

This block sits between a synchronous host and an asynchronous 256K x 16 extended-data-out DRAM whose address pins are shared between row and column. The host issues one access at a time: an 18-bit word address, a read/write flag, a two-bit byte enable and 16 bits of write data. Reads come back on a data port qualified by a one-cycle valid strobe. On the memory side the controller sequences the row strobe, two column strobes (one per byte lane), the write strobe and the output enable. It drives a 9-bit shared address and a 16-bit data bus that is split into output, drive-enable and input signals so that the pad ring can build the bidirectional bus.

Every analog timing limit is a parameter counted in clock cycles. The precharge gap, the row-to-column delay, the row-address hold and the three read-access limits can therefore be set to match any clock. An external refresh engine takes the memory pins through a request/grant pair. The grant is given only between host accesses.

Top module: `edo_ctrl`

## Requirements
- R1: After reset every memory strobe (`dram_ras_n`, `dram_lcas_n`, `dram_ucas_n`, `dram_we_n`, `dram_oe_n`) is high, `dram_dq_oe` and `rd_valid` are low, `ref_gnt` is low and `ready` is high.
- R2: `req_addr[17:9]` is on `dram_addr` when `dram_ras_n` falls, and `req_addr[8:0]` is on `dram_addr` when a column strobe falls. The column address stays steady while the column strobes are low.
- R3: `req_be[0]` selects the low lane `dq[7:0]` through `dram_lcas_n`, and `req_be[1]` selects the high lane `dq[15:8]` through `dram_ucas_n`. A word access sets both bits. A column strobe is low only while `dram_ras_n` is low.
- R4: A read holds `dram_we_n` high and pulls `dram_oe_n` low while the column strobes are low. The result appears on `rd_data` with `rd_valid` high for one cycle, and a lane whose enable bit is 0 reads as 8'h00.
- R5: A write pulls `dram_we_n` low before any column strobe falls and keeps `dram_oe_n` high. The byte in a lane whose enable bit is 0 is left unchanged in memory.
- R6: Between two low periods of `dram_ras_n`, it stays high for at least `T_RP` cycles.
- R7: Read data is sampled at a clock edge at which at least `T_RAC` cycles have passed since the row strobe fell, at least `T_CAC` since the column strobe fell, and at least `T_AA` since the column address was put on the bus.
- R8: `dram_dq_oe` rises only after a cycle in which the row strobe and both column strobes were high. It is never high while `dram_oe_n` is low.
- R9: `ready` is high only when the controller is idle with no refresh pending. A request is taken when `req` and `ready` are both high. A request raised while `ready` is low starts no memory cycle and writes nothing.
- R10: A refresh request that arrives during an access is granted only after that access and its precharge have finished. It takes priority over a host request waiting at the same moment. `ref_gnt` stays high while `ref_req` is held, and during the grant the row strobe and the column strobes stay high.
- R11: A write never produces an `rd_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Host access request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address, row in the upper 9 bits |
| req_be | input | 2 | Byte enables, bit 0 low lane, bit 1 high lane |
| req_wdata | input | 16 | Write data |
| ready | output | 1 | Controller can take a request this cycle |
| rd_data | output | 16 | Read result |
| rd_valid | output | 1 | One-cycle strobe for `rd_data` |
| ref_req | input | 1 | Refresh engine asks for the memory |
| ref_gnt | output | 1 | Memory handed to the refresh engine |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_lcas_n | output | 1 | Low-lane column strobe, active low |
| dram_ucas_n | output | 1 | High-lane column strobe, active low |
| dram_we_n | output | 1 | Write strobe, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | 9 | Shared row/column address |
| dram_dq_out | output | 16 | Data to memory |
| dram_dq_oe | output | 1 | Drive enable for `dram_dq_out` |
| dram_dq_in | input | 16 | Data from memory bus |

## Verification
Some rules are checked by assertions on every cycle. These are the precharge gap (tracked by a run-length counter), data-driver turn-on only after all strobes have been high, column strobes nested inside the row strobe, write strobe low before a column strobe falls, a steady column address, and refresh grants with idle pins. Other behaviour only the bench's scenarios can show. A behavioural memory model in the bench returns a poison pattern until all three access limits are met, which exposes a too-early capture. Read-after-write data shows the row/column split, byte-lane masking and whether an ignored busy request left memory untouched. Refresh priority over a waiting host request is shown by a directed scenario.

// File: rtl/edo_pkg.sv
package edo_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ROW,
    ST_RCD,
    ST_CAS,
    ST_PRE,
    ST_REF
  } edo_state_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Cycles the column strobe must stay low on a read so that the row,
  // column-strobe and column-address access limits are all met at the
  // sampling edge.
  function automatic int rd_cas_cycles(input int t_rac, input int t_rcd,
                                       input int t_rah, input int t_cac,
                                       input int t_aa);
    int n;
    n = imax(t_cac, 1);
    n = imax(n, t_rac - t_rcd);
    n = imax(n, t_aa - (t_rcd - t_rah));
    return n;
  endfunction

  function automatic int cnt_bits(input int maxv);
    return imax(1, $clog2(maxv + 1));
  endfunction

endpackage

// File: rtl/edo_timer.sv
module edo_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt,
  output logic         zero
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/edo_fsm.sv
module edo_fsm
  import edo_pkg::*;
#(
  parameter int T_RP   = 8,
  parameter int T_RCD  = 5,
  parameter int T_RAH  = 2,
  parameter int T_RAC  = 13,
  parameter int T_CAC  = 4,
  parameter int T_AA   = 7,
  parameter int T_WCAS = 3,
  parameter int TW     = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          req_we,
  input  logic          ref_req,
  input  logic [TW-1:0] tmr_cnt,
  input  logic          tmr_zero,
  output logic          tmr_load,
  output logic [TW-1:0] tmr_val,
  output logic          accept,
  output logic          ready,
  output logic          ref_gnt,
  output logic          ras_n,
  output logic          cas_act,
  output logic          we_n,
  output logic          oe_n,
  output logic          dq_oe,
  output logic          col_sel,
  output logic          capture
);
  localparam int RD_CYC = rd_cas_cycles(T_RAC, T_RCD, T_RAH, T_CAC, T_AA);

  edo_state_e state_q, state_d;
  logic       op_we_q;

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (state_q)
      ST_IDLE: begin
        if (ref_req)  state_d = ST_REF;
        else if (req) state_d = ST_ROW;
      end
      ST_ROW: begin
        state_d  = ST_RCD;
        tmr_load = 1'b1;
        tmr_val  = TW'(T_RCD - 1);
      end
      ST_RCD: if (tmr_zero) begin
        state_d  = ST_CAS;
        tmr_load = 1'b1;
        tmr_val  = op_we_q ? TW'(T_WCAS - 1) : TW'(RD_CYC - 1);
      end
      ST_CAS: if (tmr_zero) begin
        state_d  = ST_PRE;
        tmr_load = 1'b1;
        tmr_val  = TW'(T_RP - 1);
      end
      ST_PRE: if (tmr_zero) state_d = ST_IDLE;
      ST_REF: if (!ref_req) begin
        state_d  = ST_PRE;
        tmr_load = 1'b1;
        tmr_val  = TW'(T_RP - 1);
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      op_we_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) op_we_q <= req_we;
    end
  end

  assign ready   = (state_q == ST_IDLE) && !ref_req;
  assign accept  = ready && req;
  assign ref_gnt = (state_q == ST_REF);
  assign ras_n   = !((state_q == ST_RCD) || (state_q == ST_CAS));
  assign cas_act = (state_q == ST_CAS);
  assign we_n    = !(op_we_q && ((state_q == ST_ROW) || (state_q == ST_RCD) ||
                                 (state_q == ST_CAS)));
  assign oe_n    = !((state_q == ST_CAS) && !op_we_q);
  assign dq_oe   = op_we_q && ((state_q == ST_RCD) || (state_q == ST_CAS));
  assign col_sel = (state_q == ST_CAS) ||
                   ((state_q == ST_RCD) && (tmr_cnt < TW'(T_RCD - T_RAH)));
  assign capture = (state_q == ST_CAS) && tmr_zero && !op_we_q;

  // Run length of the row strobe's high phase; reset counts as precharged.
  logic [TW-1:0] hi_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       hi_run <= TW'(T_RP);
    else if (!ras_n)                  hi_run <= '0;
    else if (hi_run < TW'(T_RP))      hi_run <= hi_run + 1'b1;
  end

  // R6
  precharge_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (hi_run >= TW'(T_RP)));

  // R8
  driver_turn_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dq_oe) |-> $past(ras_n && !cas_act));

  // R8
  no_bus_fight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> oe_n);

  // R5
  early_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cas_act) && !we_n) |-> $past(!we_n));

  // R10
  refresh_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_gnt |-> (ras_n && !cas_act && !dq_oe));

  // R10
  grant_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ref_gnt) |-> $past(ref_req));

  // R9
  busy_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !ready);
endmodule

// File: rtl/edo_datapath.sv
module edo_datapath #(
  parameter int ROW_W  = 9,
  parameter int COL_W  = 9,
  parameter int DATA_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     accept,
  input  logic [ROW_W+COL_W-1:0]   req_addr,
  input  logic [DATA_W/8-1:0]      req_be,
  input  logic [DATA_W-1:0]        req_wdata,
  input  logic                     col_sel,
  input  logic                     cas_act,
  input  logic                     capture,
  output logic [ROW_W-1:0]         mem_addr,
  output logic [DATA_W/8-1:0]      cas_n,
  output logic [DATA_W-1:0]        dq_out,
  input  logic [DATA_W-1:0]        dq_in,
  output logic [DATA_W-1:0]        rd_data,
  output logic                     rd_valid
);
  localparam int LANES  = DATA_W / 8;
  localparam int ADDR_W = ROW_W + COL_W;

  logic [ADDR_W-1:0] addr_q;
  logic [LANES-1:0]  be_q;
  logic [DATA_W-1:0] wdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      be_q    <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      be_q    <= req_be;
      wdata_q <= req_wdata;
    end
  end

  assign mem_addr = col_sel ? ROW_W'(addr_q[COL_W-1:0]) : addr_q[ADDR_W-1:COL_W];
  assign dq_out   = wdata_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign cas_n[g] = !(cas_act && be_q[g]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       rd_data[g*8 +: 8] <= '0;
      else if (capture) rd_data[g*8 +: 8] <= be_q[g] ? dq_in[g*8 +: 8] : 8'h00;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_valid <= 1'b0;
    else        rd_valid <= capture;
  end

  // R2
  column_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_act && $past(cas_act)) |-> $stable(mem_addr));
endmodule

// File: rtl/edo_ctrl.sv
module edo_ctrl
  import edo_pkg::*;
#(
  parameter int ROW_W  = 9,
  parameter int COL_W  = 9,
  parameter int DATA_W = 16,
  parameter int T_RP   = 8,
  parameter int T_RCD  = 5,
  parameter int T_RAH  = 2,
  parameter int T_RAC  = 13,
  parameter int T_CAC  = 4,
  parameter int T_AA   = 7,
  parameter int T_WCAS = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req,
  input  logic                   req_we,
  input  logic [ROW_W+COL_W-1:0] req_addr,
  input  logic [1:0]             req_be,
  input  logic [DATA_W-1:0]      req_wdata,
  output logic                   ready,
  output logic [DATA_W-1:0]      rd_data,
  output logic                   rd_valid,
  input  logic                   ref_req,
  output logic                   ref_gnt,
  output logic                   dram_ras_n,
  output logic                   dram_lcas_n,
  output logic                   dram_ucas_n,
  output logic                   dram_we_n,
  output logic                   dram_oe_n,
  output logic [ROW_W-1:0]       dram_addr,
  output logic [DATA_W-1:0]      dram_dq_out,
  output logic                   dram_dq_oe,
  input  logic [DATA_W-1:0]      dram_dq_in
);
  localparam int RD_CYC = rd_cas_cycles(T_RAC, T_RCD, T_RAH, T_CAC, T_AA);
  localparam int MAXT   = imax(imax(T_RP, T_RCD), imax(RD_CYC, T_WCAS));
  localparam int TW     = cnt_bits(MAXT);

  logic          tmr_load, tmr_zero;
  logic [TW-1:0] tmr_val, tmr_cnt;
  logic          accept, cas_act, col_sel, capture;
  logic [1:0]    cas_n;

  edo_timer #(.W(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
    .cnt(tmr_cnt), .zero(tmr_zero)
  );

  edo_fsm #(
    .T_RP(T_RP), .T_RCD(T_RCD), .T_RAH(T_RAH), .T_RAC(T_RAC),
    .T_CAC(T_CAC), .T_AA(T_AA), .T_WCAS(T_WCAS), .TW(TW)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we), .ref_req(ref_req),
    .tmr_cnt(tmr_cnt), .tmr_zero(tmr_zero), .tmr_load(tmr_load),
    .tmr_val(tmr_val), .accept(accept), .ready(ready), .ref_gnt(ref_gnt),
    .ras_n(dram_ras_n), .cas_act(cas_act), .we_n(dram_we_n),
    .oe_n(dram_oe_n), .dq_oe(dram_dq_oe), .col_sel(col_sel),
    .capture(capture)
  );

  edo_datapath #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .accept(accept), .req_addr(req_addr),
    .req_be(req_be), .req_wdata(req_wdata), .col_sel(col_sel),
    .cas_act(cas_act), .capture(capture), .mem_addr(dram_addr),
    .cas_n(cas_n), .dq_out(dram_dq_out), .dq_in(dram_dq_in),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  assign dram_lcas_n = cas_n[0];
  assign dram_ucas_n = cas_n[1];

  // R3
  cas_inside_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dram_lcas_n || !dram_ucas_n) |-> !dram_ras_n);

  // R4
  read_not_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_oe_n |-> dram_we_n);

  // R11
  valid_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(!dram_oe_n));
endmodule

// File: tb/edo_ctrl_tb.sv
module edo_ctrl_tb;
  localparam int T_RP = 8, T_RAC = 13, T_CAC = 4, T_AA = 7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, req_we = 1'b0, ref_req = 1'b0;
  logic [17:0] req_addr = '0;
  logic [1:0]  req_be = '0;
  logic [15:0] req_wdata = '0;
  logic        ready, rd_valid, ref_gnt;
  logic [15:0] rd_data;
  logic        dram_ras_n, dram_lcas_n, dram_ucas_n, dram_we_n, dram_oe_n;
  logic [8:0]  dram_addr;
  logic [15:0] dram_dq_out, dram_dq_in;
  logic        dram_dq_oe;

  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  edo_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we),
    .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .ready(ready), .rd_data(rd_data), .rd_valid(rd_valid),
    .ref_req(ref_req), .ref_gnt(ref_gnt), .dram_ras_n(dram_ras_n),
    .dram_lcas_n(dram_lcas_n), .dram_ucas_n(dram_ucas_n),
    .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n), .dram_addr(dram_addr),
    .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe),
    .dram_dq_in(dram_dq_in)
  );

  task automatic chk(input bit ok, input string rq, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // ---------------- behavioural memory model ----------------
  logic [15:0] mem [int];
  logic [15:0] shadow [int];
  logic [8:0]  row_lat = '0, col_lat = '0, addr_prev = '0;
  logic        ras_prev = 1'b1, lc_prev = 1'b1, uc_prev = 1'b1;
  logic [15:0] mem_word = '0;
  int          cnt_ras = 0, cnt_cas = 0, cnt_col = 0, col_el;
  int          ras_hi = 1000, ras_falls = 0, rv_count = 0;
  logic        any_cas, mdl_drive, mdl_valid;
  logic [15:0] rd_word;

  function automatic logic [15:0] mem_get(input int k);
    return mem.exists(k) ? mem[k] : 16'h0000;
  endfunction
  function automatic logic [15:0] shadow_get(input int k);
    return shadow.exists(k) ? shadow[k] : 16'h0000;
  endfunction

  assign any_cas   = !dram_lcas_n || !dram_ucas_n;
  assign mdl_drive = !dram_ras_n && any_cas && !dram_oe_n;
  assign col_el    = (dram_addr == addr_prev) ? cnt_col : 0;
  assign mdl_valid = (cnt_ras + 1 >= T_RAC) && (cnt_cas + 1 >= T_CAC) &&
                     (col_el + 1 >= T_AA);
  assign rd_word   = !mdl_valid ? 16'hBAD0 :
                     {(!dram_ucas_n ? mem_word[15:8] : 8'hEE),
                      (!dram_lcas_n ? mem_word[7:0]  : 8'hEE)};
  assign dram_dq_in = dram_dq_oe ? dram_dq_out : (mdl_drive ? rd_word : 16'h5A5A);

  always @(posedge clk) begin
    if (rst_n) begin
      int k;
      logic [15:0] w;
      k = int'({row_lat, dram_addr});
      if (!dram_ras_n && ras_prev) begin
        row_lat = dram_addr;
        ras_falls++;
        // R6: precharge gap seen on the pins
        chk(ras_hi >= T_RP, "R6 precharge", ras_hi, T_RP);
      end
      k = int'({row_lat, dram_addr});
      if (any_cas && lc_prev && uc_prev) begin
        col_lat  = dram_addr;
        mem_word = mem_get(k);
        // R3: CAS inside RAS
        chk(!dram_ras_n, "R3 cas inside ras", dram_ras_n, 0);
        // R5: early write, W already low when CAS falls on a write
        if (dram_dq_oe) chk(!dram_we_n && dram_oe_n, "R5 early write",
                            {dram_we_n, dram_oe_n}, 2'b01);
      end
      if (!dram_we_n && !dram_ras_n &&
          ((!dram_lcas_n && lc_prev) || (!dram_ucas_n && uc_prev))) begin
        w = mem_get(k);
        if (!dram_lcas_n) w[7:0]  = dram_dq_in[7:0];
        if (!dram_ucas_n) w[15:8] = dram_dq_in[15:8];
        mem[k] = w;
      end
      // R8: controller and memory never drive together
      if (dram_dq_oe && mdl_drive)
        chk(1'b0, "R8 bus contention", 1, 0);
      // R10: no memory cycle while granted
      if (ref_gnt) chk(dram_ras_n && !any_cas, "R10 pins idle in grant",
                       {dram_ras_n, any_cas}, 2'b10);
      if (rd_valid) rv_count++;
      cnt_ras  <= dram_ras_n ? 0 : cnt_ras + 1;
      cnt_cas  <= any_cas ? cnt_cas + 1 : 0;
      cnt_col  <= (dram_addr == addr_prev) ? cnt_col + 1 : 1;
      addr_prev <= dram_addr;
      ras_hi   <= dram_ras_n ? ras_hi + 1 : 0;
      ras_prev <= dram_ras_n;
      lc_prev  <= dram_lcas_n;
      uc_prev  <= dram_ucas_n;
    end
  end

  // ---------------- host helpers ----------------
  task automatic host_op(input bit we, input logic [17:0] a, input logic [1:0] be,
                         input logic [15:0] wd, output logic [15:0] rd);
    int guard;
    logic [15:0] s;
    guard = 0;
    rd = '0;
    @(negedge clk);
    while (!ready && guard < 300) begin @(negedge clk); guard++; end
    req = 1'b1; req_we = we; req_addr = a; req_be = be; req_wdata = wd;
    @(negedge clk);
    req = 1'b0;
    // R9: busy once taken
    chk(!ready, "R9 ready low when busy", ready, 0);
    guard = 0;
    if (!we) begin
      while (!rd_valid && guard < 100) begin @(negedge clk); guard++; end
      chk(rd_valid, "R4 rd_valid seen", rd_valid, 1);
      rd = rd_data;
    end else begin
      while (!ready && guard < 100) begin @(negedge clk); guard++; end
      s = shadow_get(int'(a));
      if (be[0]) s[7:0]  = wd[7:0];
      if (be[1]) s[15:8] = wd[15:8];
      shadow[int'(a)] = s;
    end
  endtask

  task automatic rd_chk(input logic [17:0] a, input logic [1:0] be, input string rq);
    logic [15:0] r, e;
    host_op(1'b0, a, be, 16'h0, r);
    e = shadow_get(int'(a));
    if (!be[0]) e[7:0]  = 8'h00;
    if (!be[1]) e[15:8] = 8'h00;
    chk(r === e, rq, r, e);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    chk({dram_ras_n, dram_lcas_n, dram_ucas_n, dram_we_n, dram_oe_n} === 5'h1F,
        "R1 strobes high", {dram_ras_n, dram_lcas_n, dram_ucas_n, dram_we_n, dram_oe_n}, 5'h1F);
    chk({dram_dq_oe, rd_valid, ref_gnt, ready} === 4'b0001, "R1 status",
        {dram_dq_oe, rd_valid, ref_gnt, ready}, 4'b0001);
  endtask

  task automatic t_word();
    logic [15:0] r;
    int rv0;
    rv0 = rv_count;
    host_op(1'b1, 18'h2A5C3, 2'b11, 16'h1A2B, r);
    // R2: row and column split seen by the memory
    chk({row_lat, col_lat} === 18'h2A5C3, "R2 row/col split", {row_lat, col_lat}, 18'h2A5C3);
    // R11: write gives no valid pulse
    chk(rv_count == rv0, "R11 no valid on write", rv_count, rv0);
    rd_chk(18'h2A5C3, 2'b11, "R4 R7 word read");
    host_op(1'b1, 18'h00FFF, 2'b11, 16'hC0DE, r);
    rd_chk(18'h00FFF, 2'b11, "R2 R7 second address");
    rd_chk(18'h2A5C3, 2'b11, "R2 first address intact");
  endtask

  task automatic t_lanes();
    logic [15:0] r;
    host_op(1'b1, 18'h01234, 2'b11, 16'h5566, r);
    host_op(1'b1, 18'h01234, 2'b01, 16'hFF99, r);
    rd_chk(18'h01234, 2'b11, "R3 R5 low lane write");
    host_op(1'b1, 18'h01234, 2'b10, 16'h77FF, r);
    rd_chk(18'h01234, 2'b11, "R3 R5 high lane write");
    rd_chk(18'h01234, 2'b01, "R4 low lane read");
    rd_chk(18'h01234, 2'b10, "R4 high lane read");
  endtask

  task automatic t_turnaround();
    logic [15:0] r;
    for (int i = 0; i < 4; i++) begin
      host_op(1'b1, 18'(18'h10000 + i * 18'h0201), 2'b11, 16'(16'h3000 + i * 16'h0111), r);
      rd_chk(18'(18'h10000 + i * 18'h0201), 2'b11, "R8 read after write");
    end
  endtask

  task automatic t_busy();
    logic [15:0] r;
    int f0;
    host_op(1'b1, 18'h3FE01, 2'b11, 16'hAAAA, r);
    f0 = ras_falls;
    @(negedge clk);
    req = 1'b1; req_we = 1'b1; req_addr = 18'h3FE02; req_be = 2'b11; req_wdata = 16'h1111;
    @(negedge clk);
    req = 1'b0;
    @(negedge clk);
    req = 1'b1; req_addr = 18'h3FE01; req_wdata = 16'h2222;   // while busy: ignore
    repeat (3) @(negedge clk);
    chk(!ready, "R9 still busy", ready, 0);
    req = 1'b0;
    while (!ready) @(negedge clk);
    shadow[int'(18'h3FE02)] = 16'h1111;
    chk(ras_falls - f0 == 1, "R9 one cycle only", ras_falls - f0, 1);
    rd_chk(18'h3FE01, 2'b11, "R9 ignored request wrote nothing");
  endtask

  task automatic t_refresh();
    logic [15:0] r;
    int guard;
    bit valid_before;
    // refresh raised mid-read
    @(negedge clk);
    while (!ready) @(negedge clk);
    req = 1'b1; req_we = 1'b0; req_addr = 18'h2A5C3; req_be = 2'b11;
    @(negedge clk);
    req = 1'b0;
    repeat (2) @(negedge clk);
    ref_req = 1'b1;
    chk(!ref_gnt, "R10 no grant mid access", ref_gnt, 0);
    valid_before = 1'b0;
    guard = 0;
    while (!ref_gnt && guard < 100) begin
      if (rd_valid) begin
        valid_before = 1'b1;
        chk(rd_data === 16'h1A2B, "R10 R7 read before grant", rd_data, 16'h1A2B);
      end
      @(negedge clk); guard++;
    end
    chk(valid_before, "R10 access finished first", valid_before, 1);
    repeat (5) @(negedge clk);
    chk(ref_gnt && !ready && dram_ras_n, "R10 grant held",
        {ref_gnt, ready, dram_ras_n}, 3'b101);
    ref_req = 1'b0;
    @(negedge clk);
    chk(!ref_gnt, "R10 grant released", ref_gnt, 0);
    // refresh and host request together: refresh wins
    while (!ready) @(negedge clk);
    ref_req = 1'b1;
    req = 1'b1; req_we = 1'b1; req_addr = 18'h05050; req_be = 2'b11; req_wdata = 16'hBEEF;
    @(negedge clk);
    chk(ref_gnt && dram_ras_n, "R10 refresh wins", {ref_gnt, dram_ras_n}, 2'b11);
    repeat (3) @(negedge clk);
    ref_req = 1'b0;
    guard = 0;
    while (!ready && guard < 100) begin @(negedge clk); guard++; end
    @(negedge clk);
    req = 1'b0;
    while (!ready) @(negedge clk);
    shadow[int'(18'h05050)] = 16'hBEEF;
    rd_chk(18'h05050, 2'b11, "R10 held request served after");
    host_op(1'b0, 18'h0, 2'b11, 16'h0, r);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_word();
    t_lanes();
    t_turnaround();
    t_busy();
    t_refresh();
    repeat (4) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule